// File: doc/BRIEF.md
# DMA Line-Splitting Request Sequencer

This block takes one DMA transfer at a time and turns it into a series of memory transactions, none of which crosses a cache line. A transfer is described by a start byte address, a byte count and a kind (load or store). The first transaction starts at the transfer's own address and ends no later than the end of that line. Every later transaction starts on a line boundary and covers a full line, or whatever is left of the transfer.

Only one transaction is ever in flight. After each one is issued, the block waits for its response before it works out the next one. For a store, the payload arrives one byte per cycle on a write stream. It is packed into a line-wide buffer at the right byte lanes, and the buffer is issued with a lane mask. For a load, the returned line is captured, and the requested bytes are then sent out one per cycle on a read stream.

When the last byte is done, a one-cycle completion pulse carries the transfer's ID. Each accepted transfer receives that ID from a wrapping counter, and the ID is shown to the requester at the moment of acceptance.

Top module: `dma_line_splitter`

## Requirements
- R1: `req_ready` is high only while no transfer is active. After a legal request is accepted, `busy` is high and `req_ready` is low from the next cycle until the transfer completes.
- R2: `req_kind` 0 means load and 1 means store. A request with kind 2 or 3 is taken while idle. It produces a one-cycle `bad_req` pulse in the following cycle, starts no transfer and consumes no ID.
- R3: The first transaction has `mem_addr` equal to the request address. Its `mem_len` is the request length when (address AND (LINE_BYTES-1)) plus the length is at most LINE_BYTES, and LINE_BYTES minus that offset otherwise.
- R4: Every later transaction starts at the request address plus the bytes already completed. That address is line-aligned, and its `mem_len` is the smaller of the bytes remaining and LINE_BYTES.
- R5: `mem_lanes` bit i is set exactly for lanes offset through offset+`mem_len`-1. For stores, lane offset+j carries write-stream byte number (bytes sent before this transaction)+j, and every unset lane carries zero.
- R6: At most one transaction is outstanding. `mem_valid` stays low from the handshake until the response is taken. While `mem_valid` is high and `mem_ready` is low, `mem_addr` and `mem_len` hold.
- R7: For a load, the bytes of `rsp_data` from lane offset to lane offset+`mem_len`-1 appear on `rd_byte` in increasing lane order, one per cycle, with `rd_valid` high. The offset is 0 for every transaction after the first.
- R8: Once all bytes of a transfer are done, `done` pulses for one cycle with `done_id` equal to the ID given at acceptance, and the block is idle in that same cycle.
- R9: `req_id` shows the ID that the next legal request will receive. It is 0 after reset and rises by one, modulo 2^ID_W, on each legal acceptance.
- R10: A request of length zero completes with `done` without issuing any transaction.
- R11: A response whose `rsp_is_data` (1 = read data, 0 = write acknowledge) does not match the transfer kind sets `err_flag`. The block still treats that transaction as finished. `err_flag` stays set until the next legal acceptance clears it.
- R12: After reset, `req_ready` is 1 and `busy`, `done`, `bad_req`, `mem_valid`, `wr_ready`, `rd_valid` and `err_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request taken this cycle (idle) |
| req_kind | input | 2 | 0 load, 1 store, others illegal |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Transfer length in bytes |
| req_id | output | ID_W | ID assigned to the request being accepted |
| bad_req | output | 1 | Pulse after an illegal request kind |
| wr_valid | input | 1 | Store payload byte present |
| wr_ready | output | 1 | Store payload byte taken |
| wr_byte | input | 8 | Store payload byte |
| mem_valid | output | 1 | Memory transaction present |
| mem_ready | input | 1 | Memory transaction taken |
| mem_write | output | 1 | Transaction is a store |
| mem_addr | output | ADDR_W | Transaction byte address |
| mem_len | output | log2(LINE_BYTES)+1 | Transaction length in bytes |
| mem_lanes | output | LINE_BYTES | Byte lanes covered by the transaction |
| mem_wdata | output | 8*LINE_BYTES | Line-wide store data |
| rsp_valid | input | 1 | Response present |
| rsp_is_data | input | 1 | 1 read data, 0 write acknowledge |
| rsp_data | input | 8*LINE_BYTES | Line-wide read data |
| rd_valid | output | 1 | Load byte present |
| rd_byte | output | 8 | Load byte |
| busy | output | 1 | A transfer is active |
| done | output | 1 | Completion pulse |
| done_id | output | ID_W | ID of the completed transfer |
| err_flag | output | 1 | Mismatched response seen in the current transfer |

## Verification
The bench builds the block with a 16-byte line, 10-bit addresses, 8-bit lengths and a 3-bit ID. The short line lets short requests split into several transactions. The same line size keeps offsets that start partway through a line cheap to reach, and lets a 200-byte transfer cross more than a dozen lines. The 3-bit ID wraps within the ten legal requests of the run, so the modulo increment of the counter is exercised. The memory side stalls the handshake in a repeating pattern, and one store is answered with the wrong response type.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_FILL,
    S_ISSUE,
    S_WAIT,
    S_DRAIN
  } split_state_t;

endpackage

// File: rtl/dma_split_chunk.sv
// Works out the next transaction from the transfer start and progress.
module dma_split_chunk #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          chk_en_i,
  input  logic [ADDR_W-1:0]             start_addr_i,
  input  logic [LEN_W-1:0]              total_len_i,
  input  logic [LEN_W-1:0]              done_bytes_i,
  output logic [ADDR_W-1:0]             chunk_addr_o,
  output logic [$clog2(LINE_BYTES)-1:0] chunk_off_o,
  output logic [$clog2(LINE_BYTES):0]   chunk_len_o,
  output logic                          all_done_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int CL_W  = OFF_W + 1;
  localparam int CW    = (LEN_W > CL_W) ? LEN_W : CL_W;

  logic [LEN_W-1:0] remain;
  logic [CW-1:0]    remain_x;
  logic [CW-1:0]    room_x;

  always_comb begin
    chunk_addr_o = start_addr_i + ADDR_W'(done_bytes_i);
    chunk_off_o  = chunk_addr_o[OFF_W-1:0];
    remain       = total_len_i - done_bytes_i;
    remain_x     = CW'(remain);
    room_x       = CW'(LINE_BYTES) - CW'(chunk_off_o);
    chunk_len_o  = (remain_x < room_x) ? CL_W'(remain_x) : CL_W'(room_x);
    all_done_o   = (done_bytes_i == total_len_i);
  end

  // R4: once any bytes are complete, the next transaction begins on a line boundary
  p_later_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_i && done_bytes_i != '0) |-> (chunk_off_o == '0));

  // R3: a transaction that is about to be issued is never empty and never longer than a line
  p_chunk_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en_i |-> (chunk_len_o != '0 && chunk_len_o <= CL_W'(LINE_BYTES)));

endmodule

// File: rtl/dma_split_linebuf.sv
// Line-wide byte-lane buffer: filled bytewise for stores, loaded whole for loads.
module dma_split_linebuf #(
  parameter int LINE_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clear_i,
  input  logic                          put_en_i,
  input  logic [$clog2(LINE_BYTES)-1:0] put_idx_i,
  input  logic [7:0]                    put_byte_i,
  input  logic                          load_en_i,
  input  logic [LINE_BYTES*8-1:0]       load_line_i,
  input  logic [$clog2(LINE_BYTES)-1:0] get_idx_i,
  output logic [7:0]                    get_byte_o,
  output logic [LINE_BYTES*8-1:0]       line_o
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    logic [7:0] lane_d;

    always_comb begin
      lane_d = lane_q;
      if (clear_i)
        lane_d = '0;
      else if (load_en_i)
        lane_d = load_line_i[g*8 +: 8];
      else if (put_en_i && put_idx_i == OFF_W'(g))
        lane_d = put_byte_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= '0;
      else
        lane_q <= lane_d;
    end

    assign line_o[g*8 +: 8] = lane_q;
  end

  assign get_byte_o = line_o[{get_idx_i, 3'b000} +: 8];

  // R5: the buffer is never filled from the stream and loaded from memory together
  p_one_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(put_en_i && (load_en_i || clear_i)));

endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 64,
  parameter int ID_W       = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [1:0]                    req_kind,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [LEN_W-1:0]              req_len,
  output logic [ID_W-1:0]               req_id,
  output logic                          bad_req,
  input  logic                          wr_valid,
  output logic                          wr_ready,
  input  logic [7:0]                    wr_byte,
  output logic                          mem_valid,
  input  logic                          mem_ready,
  output logic                          mem_write,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [$clog2(LINE_BYTES):0]   mem_len,
  output logic [LINE_BYTES-1:0]         mem_lanes,
  output logic [LINE_BYTES*8-1:0]       mem_wdata,
  input  logic                          rsp_valid,
  input  logic                          rsp_is_data,
  input  logic [LINE_BYTES*8-1:0]       rsp_data,
  output logic                          rd_valid,
  output logic [7:0]                    rd_byte,
  output logic                          busy,
  output logic                          done,
  output logic [ID_W-1:0]               done_id,
  output logic                          err_flag
);
  import dma_split_pkg::*;

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int CL_W  = OFF_W + 1;

  split_state_t      state_q, state_d;
  logic [ADDR_W-1:0] start_q, start_d;
  logic [LEN_W-1:0]  total_q, total_d;
  logic [LEN_W-1:0]  completed_q, completed_d;
  logic [LEN_W-1:0]  issued_q, issued_d;
  logic [ADDR_W-1:0] caddr_q, caddr_d;
  logic [OFF_W-1:0]  coff_q, coff_d;
  logic [CL_W-1:0]   clen_q, clen_d;
  logic [CL_W-1:0]   idx_q, idx_d;
  logic [ID_W-1:0]   id_ctr_q, id_ctr_d;
  logic [ID_W-1:0]   cur_id_q, cur_id_d;
  logic              wr_q, wr_d;
  logic              done_q, done_d;
  logic              bad_q, bad_d;
  logic              err_q, err_d;

  logic [ADDR_W-1:0] n_addr;
  logic [OFF_W-1:0]  n_off;
  logic [CL_W-1:0]   n_len;
  logic              n_all_done;
  logic              chk_en;
  logic              legal_kind;
  logic              last_byte;
  logic              buf_clear;
  logic              buf_put;
  logic              buf_load;
  logic [OFF_W-1:0]  lane_idx;
  logic [7:0]        buf_byte;
  logic [LINE_BYTES*8-1:0] buf_line;

  assign chk_en = (state_q == S_SETUP) && !n_all_done;

  dma_split_chunk #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .LINE_BYTES(LINE_BYTES)
  ) i_chunk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_en_i    (chk_en),
    .start_addr_i(start_q),
    .total_len_i (total_q),
    .done_bytes_i(completed_q),
    .chunk_addr_o(n_addr),
    .chunk_off_o (n_off),
    .chunk_len_o (n_len),
    .all_done_o  (n_all_done)
  );

  assign lane_idx = coff_q + OFF_W'(idx_q);

  dma_split_linebuf #(
    .LINE_BYTES(LINE_BYTES)
  ) i_linebuf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (buf_clear),
    .put_en_i   (buf_put),
    .put_idx_i  (lane_idx),
    .put_byte_i (wr_byte),
    .load_en_i  (buf_load),
    .load_line_i(rsp_data),
    .get_idx_i  (lane_idx),
    .get_byte_o (buf_byte),
    .line_o     (buf_line)
  );

  assign legal_kind = (req_kind == KIND_LOAD) || (req_kind == KIND_STORE);
  assign last_byte  = (idx_q == clen_q - CL_W'(1));

  // Next-state process
  always_comb begin
    state_d     = state_q;
    start_d     = start_q;
    total_d     = total_q;
    completed_d = completed_q;
    issued_d    = issued_q;
    caddr_d     = caddr_q;
    coff_d      = coff_q;
    clen_d      = clen_q;
    idx_d       = idx_q;
    id_ctr_d    = id_ctr_q;
    cur_id_d    = cur_id_q;
    wr_d        = wr_q;
    err_d       = err_q;
    done_d      = 1'b0;
    bad_d       = 1'b0;
    buf_clear   = 1'b0;
    buf_put     = 1'b0;
    buf_load    = 1'b0;

    case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          if (legal_kind) begin
            start_d     = req_addr;
            total_d     = req_len;
            completed_d = '0;
            issued_d    = '0;
            wr_d        = (req_kind == KIND_STORE);
            cur_id_d    = id_ctr_q;
            id_ctr_d    = id_ctr_q + ID_W'(1);
            err_d       = 1'b0;
            state_d     = S_SETUP;
          end else begin
            bad_d = 1'b1;
          end
        end
      end
      S_SETUP: begin
        if (n_all_done) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          caddr_d   = n_addr;
          coff_d    = n_off;
          clen_d    = n_len;
          issued_d  = completed_q + LEN_W'(n_len);
          idx_d     = '0;
          buf_clear = 1'b1;
          state_d   = wr_q ? S_FILL : S_ISSUE;
        end
      end
      S_FILL: begin
        if (wr_valid) begin
          buf_put = 1'b1;
          if (last_byte) begin
            idx_d   = '0;
            state_d = S_ISSUE;
          end else begin
            idx_d = idx_q + CL_W'(1);
          end
        end
      end
      S_ISSUE: begin
        if (mem_ready)
          state_d = S_WAIT;
      end
      S_WAIT: begin
        if (rsp_valid) begin
          if (rsp_is_data == wr_q)
            err_d = 1'b1;
          if (!wr_q && rsp_is_data) begin
            buf_load = 1'b1;
            idx_d    = '0;
            state_d  = S_DRAIN;
          end else begin
            completed_d = issued_q;
            state_d     = S_SETUP;
          end
        end
      end
      S_DRAIN: begin
        if (last_byte) begin
          completed_d = issued_q;
          state_d     = S_SETUP;
        end else begin
          idx_d = idx_q + CL_W'(1);
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      start_q     <= '0;
      total_q     <= '0;
      completed_q <= '0;
      issued_q    <= '0;
      caddr_q     <= '0;
      coff_q      <= '0;
      clen_q      <= '0;
      idx_q       <= '0;
      id_ctr_q    <= '0;
      cur_id_q    <= '0;
      wr_q        <= 1'b0;
      done_q      <= 1'b0;
      bad_q       <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      start_q     <= start_d;
      total_q     <= total_d;
      completed_q <= completed_d;
      issued_q    <= issued_d;
      caddr_q     <= caddr_d;
      coff_q      <= coff_d;
      clen_q      <= clen_d;
      idx_q       <= idx_d;
      id_ctr_q    <= id_ctr_d;
      cur_id_q    <= cur_id_d;
      wr_q        <= wr_d;
      done_q      <= done_d;
      bad_q       <= bad_d;
      err_q       <= err_d;
    end
  end

  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lanes
    assign mem_lanes[g] = (CL_W'(g) >= CL_W'(coff_q)) &&
                          (CL_W'(g) <  CL_W'(coff_q) + clen_q);
  end

  assign req_ready = (state_q == S_IDLE);
  assign req_id    = id_ctr_q;
  assign bad_req   = bad_q;
  assign wr_ready  = (state_q == S_FILL);
  assign mem_valid = (state_q == S_ISSUE);
  assign mem_write = wr_q;
  assign mem_addr  = caddr_q;
  assign mem_len   = clen_q;
  assign mem_wdata = buf_line;
  assign rd_valid  = (state_q == S_DRAIN);
  assign rd_byte   = buf_byte;
  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign done_id   = cur_id_q;
  assign err_flag  = err_q;

  // R1: a legal acceptance makes the block busy and closes the request port
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && legal_kind) |=> (busy && !req_ready));

  // R2: an illegal kind gives a pulse and leaves the block idle
  p_illegal_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !legal_kind) |=> (bad_req && !busy));

  // R5: the lane mask covers exactly the transaction length
  p_lane_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ($countones(mem_lanes) == int'(mem_len)));

  // R6: a stalled transaction holds its address and length
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_len)));

  // R6: no new transaction until the response to the previous one is taken
  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> !mem_valid);

  // R8: completion happens only with every byte done and the block idle
  p_done_complete_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (completed_q == total_q && !busy));

endmodule

// File: tb/test_dma_line_splitter.sv
module test_dma_line_splitter;
  localparam int AW = 10;
  localparam int LW = 8;
  localparam int LB = 16;
  localparam int IW = 3;
  localparam int OW = 4;
  localparam int DW = LB * 8;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_kind;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic [IW-1:0] req_id;
  logic          bad_req;
  logic          wr_valid;
  logic          wr_ready;
  logic [7:0]    wr_byte;
  logic          mem_valid;
  logic          mem_ready;
  logic          mem_write;
  logic [AW-1:0] mem_addr;
  logic [OW:0]   mem_len;
  logic [LB-1:0] mem_lanes;
  logic [DW-1:0] mem_wdata;
  logic          rsp_valid;
  logic          rsp_is_data;
  logic [DW-1:0] rsp_data;
  logic          rd_valid;
  logic [7:0]    rd_byte;
  logic          busy;
  logic          done;
  logic [IW-1:0] done_id;
  logic          err_flag;

  dma_line_splitter #(
    .ADDR_W(AW), .LEN_W(LW), .LINE_BYTES(LB), .ID_W(IW)
  ) i_dma_line_splitter (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_len(req_len), .req_id(req_id), .bad_req(bad_req),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_byte(wr_byte),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_len(mem_len), .mem_lanes(mem_lanes), .mem_wdata(mem_wdata),
    .rsp_valid(rsp_valid), .rsp_is_data(rsp_is_data), .rsp_data(rsp_data),
    .rd_valid(rd_valid), .rd_byte(rd_byte),
    .busy(busy), .done(done), .done_id(done_id), .err_flag(err_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem_m [0:(1<<AW)-1];
  int         exp_caddr[$];
  int         exp_clen[$];
  logic [7:0] exp_wpay[$];
  logic [7:0] feed[$];
  logic [7:0] exp_rd[$];
  int         exp_id = 0;
  int         exp_done_id = 0;
  int         done_seen = 0;
  bit         outstanding = 0;
  int         pend_cnt = 0;
  logic [AW-1:0] pend_addr;
  bit         pend_wr = 0;
  bit         inject_bad = 0;
  int         cyc = 0;
  bit         finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic end_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Reference model of the memory side and stream monitors, evaluated every clock
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        chk(busy == !req_ready, "R1", "busy vs req_ready", busy, !req_ready);
        rsp_valid = 1'b0;
        if (pend_cnt > 0) begin
          pend_cnt--;
          if (pend_cnt == 0) begin
            rsp_valid   = 1'b1;
            rsp_is_data = pend_wr ? inject_bad : 1'b1;
            for (int i = 0; i < LB; i++)
              rsp_data[i*8 +: 8] = mem_m[{pend_addr[AW-1:OW], OW'(i)}];
            outstanding = 0;
          end
        end
        mem_ready = (cyc % 3) != 1;
        if (mem_valid) begin
          chk(!outstanding, "R6", "issue while outstanding", 1, 0);
          if (mem_ready) begin
            if (exp_caddr.size() == 0) begin
              chk(0, "R10", "unexpected transaction", mem_addr, 0);
            end else begin
              int ea;
              int el;
              int off;
              ea = exp_caddr.pop_front();
              el = exp_clen.pop_front();
              off = ea % LB;
              chk(int'(mem_addr) == ea, "R3/R4", "mem_addr", mem_addr, ea);
              chk(int'(mem_len) == el, "R3/R4", "mem_len", mem_len, el);
              for (int i = 0; i < LB; i++) begin
                bit want;
                want = (i >= off) && (i < off + el);
                chk(mem_lanes[i] == want, "R5", "lane bit", mem_lanes[i], want);
                if (mem_write) begin
                  logic [7:0] eb;
                  eb = want ? exp_wpay.pop_front() : 8'h00;
                  chk(mem_wdata[i*8 +: 8] == eb, "R5", "store lane", mem_wdata[i*8 +: 8], eb);
                  if (want) mem_m[{mem_addr[AW-1:OW], OW'(i)}] = mem_wdata[i*8 +: 8];
                end
              end
            end
            outstanding = 1;
            pend_cnt    = 2;
            pend_wr     = mem_write;
            pend_addr   = mem_addr;
          end
        end
        wr_valid = feed.size() > 0;
        wr_byte  = wr_valid ? feed[0] : 8'h00;
        if (wr_valid && wr_ready) void'(feed.pop_front());
        if (rd_valid) begin
          if (exp_rd.size() == 0) chk(0, "R7", "extra read byte", rd_byte, 0);
          else begin
            logic [7:0] eb;
            eb = exp_rd.pop_front();
            chk(rd_byte == eb, "R7", "read byte", rd_byte, eb);
          end
        end
        if (done) begin
          chk(int'(done_id) == exp_done_id, "R8", "done_id", done_id, exp_done_id);
          chk(exp_caddr.size() == 0, "R8", "chunks left at done", exp_caddr.size(), 0);
          done_seen++;
        end
      end
    end
  end

  task automatic do_req(input int kind, input int addr, input int len);
    bit legal;
    int start_done;
    legal = kind < 2;
    if (legal) begin
      int pos;
      pos = 0;
      while (pos < len) begin
        int a;
        int n;
        a = addr + pos;
        n = len - pos;
        if (n > LB - (a % LB)) n = LB - (a % LB);
        exp_caddr.push_back(a);
        exp_clen.push_back(n);
        pos += n;
      end
      for (int p = 0; p < len; p++) begin
        if (kind == 1) begin
          logic [7:0] b;
          b = 8'((p * 37 + addr) ^ 8'h5A);
          feed.push_back(b);
          exp_wpay.push_back(b);
        end else begin
          exp_rd.push_back(mem_m[addr + p]);
        end
      end
      exp_done_id = exp_id;
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_kind  = 2'(kind);
    req_addr  = AW'(addr);
    req_len   = LW'(len);
    if (legal) chk(int'(req_id) == exp_id, "R9", "req_id", req_id, exp_id);
    start_done = done_seen;
    @(negedge clk);
    if (!legal) begin
      chk(bad_req == 1'b1, "R2", "bad_req pulse", bad_req, 1);
      chk(!busy, "R2", "busy after illegal", busy, 0);
      req_valid = 1'b0;
      @(negedge clk);
      chk(bad_req == 1'b0, "R2", "bad_req one cycle", bad_req, 0);
      return;
    end
    chk(busy && !req_ready, "R1", "busy after accept", {busy, req_ready}, 2);
    chk(err_flag == 1'b0, "R11", "err_flag cleared on accept", err_flag, 0);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    while (done_seen == start_done) begin
      @(negedge clk);
      #1;
    end
    exp_id = (exp_id + 1) % (1 << IW);
    chk(exp_rd.size() == 0 && feed.size() == 0, "R7", "stream bytes left", exp_rd.size() + feed.size(), 0);
    chk(!busy && req_ready, "R8", "idle after done", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    end_run();
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem_m[i] = 8'((i * 7 + 3) & 255);
    rst_n = 0; req_valid = 0; req_kind = 0; req_addr = 0; req_len = 0;
    wr_valid = 0; wr_byte = 0; mem_ready = 0; rsp_valid = 0; rsp_is_data = 0; rsp_data = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(req_ready == 1, "R12", "req_ready", req_ready, 1);
    chk(!busy && !done && !bad_req, "R12", "busy/done/bad", {busy, done, bad_req}, 0);
    chk(!mem_valid && !wr_ready && !rd_valid, "R12", "port valids", {mem_valid, wr_ready, rd_valid}, 0);
    chk(!err_flag && req_id == 0, "R12", "err/id", {err_flag, req_id}, 0);
    rst_n = 1;
    do_req(2, 'h040, 4);            // R2
    do_req(3, 'h050, 4);            // R2
    do_req(0, 'h070, 0);            // R10: zero-length load
    do_req(1, 'h080, 0);            // R10: zero-length store
    do_req(0, 'h105, 5);            // R3: within one line
    do_req(0, 'h10C, 30);           // R3 R4 R7: split 4/16/10
    do_req(1, 'h200, 32);           // R4 R5: aligned store
    do_req(1, 'h233, 21);           // R3 R5: unaligned store 13/8
    do_req(0, 'h230, 40);           // R7: read back stored bytes
    inject_bad = 1;
    do_req(1, 'h300, 20);           // R11: store answered with data
    inject_bad = 0;
    chk(err_flag == 1, "R11", "err_flag set", err_flag, 1);
    do_req(0, 'h300, 16);           // R11: cleared on accept; R9 wrap
    do_req(0, 'h2F1, 200);          // R4 R7: long transfer
    chk(done_seen == 10, "R8", "one done per transfer", done_seen, 10);
    repeat (4) @(negedge clk);
    end_run();
  end

endmodule